// File: doc/BRIEF.md
# LFSR Reload Clock Divider

This block divides an input clock by ratios that software chooses as shift-register seeds rather than as binary counts. Each of two dividers runs a linear feedback shift register that steps once per input cycle. When the register arrives at its fixed terminal state, it reloads from a seed register and the divider output toggles. A seed that lies N−1 steps ahead of the terminal state therefore gives one output toggle every N input cycles, and the output period is 2N cycles. The narrow reference divider (6 bits) covers ratios 1 to 64. The wide feedback divider (8 bits) covers ratios 2 to 160. In both, the all-zero state steps directly into the terminal state.

A two-stage post-divider follows, programmed through one 6-bit code. Each 3-bit field holds eight minus the stage ratio, and the total ratio is the product of the two stage ratios. The block rejects codes in which the upper stage divides by more than the lower stage. A code that asks for a ratio of 8 in either stage is applied through a bridge. For a fixed settle window, the block first applies the same code with bits 0 and 3 forced high, and then the final code.

Top module: `lfsr_clkdiv`

## Requirements
- R1: On the reference divider, seed codes 0x3f, 0x00, 0x20, 0x10, 0x0a, 0x25, 0x08 and 0x01 give ratios 1, 2, 3, 4, 9, 10, 20 and 64. `ref_clk_o` toggles every N cycles, for a period of 2N cycles.
- R2: On the feedback divider, seed codes 0x00, 0x80, 0xc0, 0x2f, 0x70, 0x6e, 0x3c and 0x69 give ratios 2, 3, 4, 10, 16, 40, 100 and 160. `fb_clk_o` toggles every N cycles.
- R3: A divider output toggles only on the cycle after its register holds the terminal state. A seed written in the middle of a half-period does not shorten that half-period, and it applies from the next half-period onward.
- R4: While `rst_ni` is low, all three clock outputs are 0 and `post_cfg_o` is 0x3f. After release the seeds return to their defaults (reference ratio 1, feedback ratio 2): `ref_clk_o` rises on the first edge and `fb_clk_o` rises on the second edge.
- R5: In a post code, bits [5:3] hold 8−d2 and bits [2:0] hold 8−d1. An accepted code appears on `post_cfg_o` on the edge that samples the write. `post_clk_o` then toggles every d1·d2 cycles.
- R6: A post write whose d2 exceeds d1 (field [5:3] below field [2:0]) is ignored, and `post_cfg_o` keeps its value.
- R7: An accepted post code with either field equal to 0 shows code|0x09 on `post_cfg_o` for SETTLE_CYC cycles and then the code itself.
- R8: Post writes that arrive while a bridge window is open are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock being divided |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_we_i | input | 1 | Write strobe for the reference seed |
| ref_code_i | input | 6 | Reference divider seed code |
| fb_we_i | input | 1 | Write strobe for the feedback seed |
| fb_code_i | input | 8 | Feedback divider seed code |
| post_we_i | input | 1 | Write strobe for the post-divider code |
| post_code_i | input | 6 | Post-divider code, fields 8−d2 and 8−d1 |
| ref_clk_o | output | 1 | Reference divider output |
| fb_clk_o | output | 1 | Feedback divider output |
| post_clk_o | output | 1 | Post-divider output |
| post_cfg_o | output | 6 | Post code currently applied to the stages |

## Verification
A wrong feedback tap or a wrong terminal comparison does not show as a constant error. It shows as a half-period that is too long or too short for a given seed. It surfaces within one output period, at most 320 cycles for the largest feedback ratio. A reload that takes the seed at the wrong moment shows as a half-period that is too short right after a mid-interval write. Faults in the post-divider path show up directly on `post_cfg_o`, on the cycle after the write or after the settle window: a dropped bridge, a wrong bridge mask or a missing order check. Counter faults in the post-divider stages show as a wrong toggle spacing within 64 cycles.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int unsigned POST_FW     = 3;
  localparam int unsigned POST_STAGES = 2;
  localparam int unsigned POST_CW     = POST_FW * POST_STAGES;

  typedef enum logic {SEQ_IDLE, SEQ_BRIDGE} seq_state_e;

  // lowest bit of every stage field
  function automatic logic [POST_CW-1:0] bridge_mask();
    logic [POST_CW-1:0] m;
    m = '0;
    for (int s = 0; s < POST_STAGES; s++) m[s*POST_FW] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/lfsr_reload_div.sv
module lfsr_reload_div #(
  parameter int unsigned    W        = 6,
  parameter logic [W-1:0]   TAPS     = 6'h30,
  parameter logic [W-1:0]   TERM     = 6'h3f,
  parameter logic [W-1:0]   RST_CODE = 6'h3f
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] code_i,
  output logic         div_o
);
  logic [W-1:0] reload_q, lfsr_q, lfsr_step;
  logic         div_q, at_term;

  assign at_term = (lfsr_q == TERM);
  // all-zero jumps straight into the terminal state
  assign lfsr_step = (lfsr_q == '0) ? TERM : {lfsr_q[W-2:0], ~^(lfsr_q & TAPS)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= RST_CODE;
      lfsr_q   <= RST_CODE;
      div_q    <= 1'b0;
    end else begin
      if (we_i) reload_q <= code_i;
      if (at_term) begin
        lfsr_q <= reload_q;
        div_q  <= ~div_q;
      end else begin
        lfsr_q <= lfsr_step;
      end
    end
  end

  assign div_o = div_q;

  // R3
  toggle_at_term_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_q != $past(div_q)) |-> $past(at_term));
  // R3
  reload_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(at_term) |-> (lfsr_q == $past(reload_q)));
endmodule

// File: rtl/post_cfg_seq.sv
module post_cfg_seq
  import clkdiv_pkg::*;
#(
  parameter int unsigned          SETTLE   = 125,
  parameter logic [POST_CW-1:0]   RST_CODE = '1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [POST_CW-1:0] code_i,
  output logic [POST_CW-1:0] cfg_o,
  output logic               upd_o
);
  localparam int unsigned CNT_W = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [POST_CW-1:0] MASK = bridge_mask();

  seq_state_e         state_q;
  logic [POST_CW-1:0] cfg_q, hold_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               upd_q, code_ok, need_bridge;

  // second stage ratio must not exceed the first: its field is not smaller
  assign code_ok = code_i[POST_FW +: POST_FW] >= code_i[0 +: POST_FW];

  always_comb begin
    need_bridge = 1'b0;
    for (int s = 0; s < POST_STAGES; s++)
      if (code_i[s*POST_FW +: POST_FW] == '0) need_bridge = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      cfg_q   <= RST_CODE;
      hold_q  <= RST_CODE;
      cnt_q   <= '0;
      upd_q   <= 1'b0;
    end else begin
      upd_q <= 1'b0;
      case (state_q)
        SEQ_IDLE: begin
          if (we_i && code_ok) begin
            upd_q <= 1'b1;
            if (need_bridge) begin
              cfg_q   <= code_i | MASK;
              hold_q  <= code_i;
              cnt_q   <= CNT_W'(SETTLE - 1);
              state_q <= SEQ_BRIDGE;
            end else begin
              cfg_q <= code_i;
            end
          end
        end
        SEQ_BRIDGE: begin
          if (cnt_q == '0) begin
            cfg_q   <= hold_q;
            upd_q   <= 1'b1;
            state_q <= SEQ_IDLE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign cfg_o = cfg_q;
  assign upd_o = upd_q;

  // R7
  bridge_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_BRIDGE) |-> ((cfg_q & MASK) == MASK));
  // R6
  stage_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q[POST_FW +: POST_FW] >= cfg_q[0 +: POST_FW]);
  // R8
  bridge_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q == SEQ_BRIDGE) && state_q == SEQ_BRIDGE) |-> $stable(cfg_q));
endmodule

// File: rtl/post_div_stage.sv
module post_div_stage #(
  parameter int unsigned FW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic [FW-1:0] field_i,
  output logic          tick_o
);
  logic [FW-1:0] cnt_q, lim;

  // ratio is 2**FW - field, so the last count is ~field
  assign lim    = ~field_i;
  assign tick_o = tick_i & ~clr_i & (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (tick_i)  cnt_q <= (cnt_q == lim) ? '0 : cnt_q + 1'b1;
  end

  // R5
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |-> (cnt_q <= lim));
endmodule

// File: rtl/lfsr_clkdiv.sv
module lfsr_clkdiv
  import clkdiv_pkg::*;
#(
  parameter int unsigned        REF_W      = 6,
  parameter int unsigned        FB_W       = 8,
  parameter logic [REF_W-1:0]   REF_TAPS   = 6'h30,
  parameter logic [REF_W-1:0]   REF_TERM   = 6'h3f,
  parameter logic [REF_W-1:0]   REF_RST    = 6'h3f,
  parameter logic [FB_W-1:0]    FB_TAPS    = 8'h8e,
  parameter logic [FB_W-1:0]    FB_TERM    = 8'h01,
  parameter logic [FB_W-1:0]    FB_RST     = 8'h00,
  parameter int unsigned        SETTLE_CYC = 125
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ref_we_i,
  input  logic [REF_W-1:0]   ref_code_i,
  input  logic               fb_we_i,
  input  logic [FB_W-1:0]    fb_code_i,
  input  logic               post_we_i,
  input  logic [POST_CW-1:0] post_code_i,
  output logic               ref_clk_o,
  output logic               fb_clk_o,
  output logic               post_clk_o,
  output logic [POST_CW-1:0] post_cfg_o
);
  logic [POST_CW-1:0]   cfg;
  logic                 upd;
  logic [POST_STAGES:0] tick;
  logic                 post_q;

  lfsr_reload_div #(.W(REF_W), .TAPS(REF_TAPS), .TERM(REF_TERM), .RST_CODE(REF_RST)) u_ref (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(ref_we_i), .code_i(ref_code_i), .div_o(ref_clk_o)
  );

  lfsr_reload_div #(.W(FB_W), .TAPS(FB_TAPS), .TERM(FB_TERM), .RST_CODE(FB_RST)) u_fb (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(fb_we_i), .code_i(fb_code_i), .div_o(fb_clk_o)
  );

  post_cfg_seq #(.SETTLE(SETTLE_CYC), .RST_CODE('1)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(post_we_i), .code_i(post_code_i),
    .cfg_o(cfg), .upd_o(upd)
  );

  assign tick[0] = 1'b1;

  for (genvar g = 0; g < POST_STAGES; g++) begin : g_stage
    post_div_stage #(.FW(POST_FW)) u_stage (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(upd), .tick_i(tick[g]),
      .field_i(cfg[g*POST_FW +: POST_FW]), .tick_o(tick[g+1])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                post_q <= 1'b0;
    else if (tick[POST_STAGES]) post_q <= ~post_q;
  end

  assign post_clk_o = post_q;
  assign post_cfg_o = cfg;

  // R5
  post_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (post_q != $past(post_q)) |-> $past(tick[POST_STAGES]));
endmodule

// File: tb/lfsr_clkdiv_tb.sv
module lfsr_clkdiv_tb;
  localparam int SETTLE = 125;
  localparam int NV     = 22;
  localparam int LIMIT  = 2000;

  // {select: 0 ref, 1 fb, 2 post; code; expected cycles per toggle}
  localparam logic [25:0] VEC [NV] = '{
    {2'd0, 8'h3f, 16'd1},   {2'd0, 8'h00, 16'd2},   {2'd0, 8'h20, 16'd3},
    {2'd0, 8'h10, 16'd4},   {2'd0, 8'h0a, 16'd9},   {2'd0, 8'h25, 16'd10},
    {2'd0, 8'h08, 16'd20},  {2'd0, 8'h01, 16'd64},
    {2'd1, 8'h00, 16'd2},   {2'd1, 8'h80, 16'd3},   {2'd1, 8'hc0, 16'd4},
    {2'd1, 8'h2f, 16'd10},  {2'd1, 8'h70, 16'd16},  {2'd1, 8'h6e, 16'd40},
    {2'd1, 8'h3c, 16'd100}, {2'd1, 8'h69, 16'd160},
    {2'd2, 8'h3f, 16'd1},   {2'd2, 8'h3e, 16'd2},   {2'd2, 8'h36, 16'd4},
    {2'd2, 8'h2d, 16'd9},   {2'd2, 8'h38, 16'd8},   {2'd2, 8'h00, 16'd64}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ref_we_i = 1'b0, fb_we_i = 1'b0, post_we_i = 1'b0;
  logic [5:0] ref_code_i = '0, post_code_i = '0;
  logic [7:0] fb_code_i = '0;
  logic       ref_clk_o, fb_clk_o, post_clk_o;
  logic [5:0] post_cfg_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  lfsr_clkdiv #(.SETTLE_CYC(SETTLE)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ref_we_i(ref_we_i), .ref_code_i(ref_code_i),
    .fb_we_i(fb_we_i), .fb_code_i(fb_code_i),
    .post_we_i(post_we_i), .post_code_i(post_code_i),
    .ref_clk_o(ref_clk_o), .fb_clk_o(fb_clk_o), .post_clk_o(post_clk_o),
    .post_cfg_o(post_cfg_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic out_of(input int sel);
    case (sel)
      0:       return ref_clk_o;
      1:       return fb_clk_o;
      default: return post_clk_o;
    endcase
  endfunction

  // write at one negedge, strobe dropped at the next (k=0 sample point)
  task automatic write_code(input int sel, input logic [7:0] code);
    @(negedge clk_i);
    case (sel)
      0:       begin ref_we_i  = 1'b1; ref_code_i  = code[5:0]; end
      1:       begin fb_we_i   = 1'b1; fb_code_i   = code;      end
      default: begin post_we_i = 1'b1; post_code_i = code[5:0]; end
    endcase
    @(negedge clk_i);
    ref_we_i = 1'b0; fb_we_i = 1'b0; post_we_i = 1'b0;
  endtask

  task automatic wait_toggle(input int sel, output int gap);
    logic lvl;
    lvl = out_of(sel);
    gap = 0;
    do begin
      @(negedge clk_i);
      gap++;
    end while (out_of(sel) == lvl && gap < LIMIT);
  endtask

  task automatic check_half(input int sel, input int exp, input string req);
    int g;
    wait_toggle(sel, g);
    wait_toggle(sel, g);
    for (int i = 0; i < 2; i++) begin
      wait_toggle(sel, g);
      chk(g == exp, req, g, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    int g;
    logic [25:0] v;

    // R4 reset state
    repeat (3) @(negedge clk_i);
    chk(ref_clk_o == 1'b0, "R4 ref in reset", ref_clk_o, 0);
    chk(fb_clk_o == 1'b0, "R4 fb in reset", fb_clk_o, 0);
    chk(post_clk_o == 1'b0, "R4 post in reset", post_clk_o, 0);
    chk(post_cfg_o == 6'h3f, "R4 cfg in reset", post_cfg_o, 'h3f);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(ref_clk_o == 1'b1, "R4 ref first edge", ref_clk_o, 1);
    chk(fb_clk_o == 1'b0, "R4 fb first edge", fb_clk_o, 0);
    @(negedge clk_i);
    chk(fb_clk_o == 1'b1, "R4 fb second edge", fb_clk_o, 1);

    // R1 R2 R5 vector walk
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      write_code(int'(v[25:24]), v[23:16]);
      if (v[25:24] == 2'd2) repeat (SETTLE + 4) @(negedge clk_i);
      case (v[25:24])
        2'd0:    check_half(0, int'(v[15:0]), "R1 ref ratio");
        2'd1:    check_half(1, int'(v[15:0]), "R2 fb ratio");
        default: check_half(2, int'(v[15:0]), "R5 post ratio");
      endcase
    end

    // R3 mid-interval seed write keeps current half-period (ref at ratio 64)
    wait_toggle(0, g);
    g = 0;
    begin
      logic lvl;
      lvl = ref_clk_o;
      do begin
        @(negedge clk_i);
        g++;
        if (g == 10) begin ref_we_i = 1'b1; ref_code_i = 6'h3f; end
        if (g == 11) ref_we_i = 1'b0;
      end while (ref_clk_o == lvl && g < LIMIT);
    end
    chk(g == 64, "R3 no runt after write", g, 64);
    wait_toggle(0, g);
    chk(g == 1, "R3 new seed next interval", g, 1);
    wait_toggle(0, g);
    chk(g == 1, "R3 new seed steady", g, 1);

    // R7 bridge for ratio 8 (post currently 0x00, idle)
    write_code(2, 8'h38);
    chk(post_cfg_o == 6'h39, "R7 bridge start", post_cfg_o, 'h39);
    repeat (SETTLE - 1) @(negedge clk_i);
    chk(post_cfg_o == 6'h39, "R7 bridge last", post_cfg_o, 'h39);
    @(negedge clk_i);
    chk(post_cfg_o == 6'h38, "R7 bridge final", post_cfg_o, 'h38);

    // R8 write during bridge is dropped
    write_code(2, 8'h00);
    chk(post_cfg_o == 6'h09, "R8 bridge value", post_cfg_o, 'h09);
    @(negedge clk_i);
    post_we_i = 1'b1; post_code_i = 6'h3f;
    @(negedge clk_i);
    post_we_i = 1'b0;
    repeat (SETTLE + 2) @(negedge clk_i);
    chk(post_cfg_o == 6'h00, "R8 busy write ignored", post_cfg_o, 'h00);

    // R6 out-of-order stages rejected
    write_code(2, 8'h2e);
    @(negedge clk_i);
    chk(post_cfg_o == 6'h00, "R6 invalid ignored", post_cfg_o, 'h00);

    // R5 plain write lands on the sampling edge
    write_code(2, 8'h36);
    chk(post_cfg_o == 6'h36, "R5 immediate cfg", post_cfg_o, 'h36);
    check_half(2, 4, "R5 post ratio after write");

    // R4 reset mid-run restores defaults
    write_code(1, 8'h69);
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    chk(ref_clk_o == 1'b0 && fb_clk_o == 1'b0 && post_clk_o == 1'b0,
        "R4 outputs cleared", {ref_clk_o, fb_clk_o, post_clk_o}, 0);
    chk(post_cfg_o == 6'h3f, "R4 cfg restored", post_cfg_o, 'h3f);
    rst_ni = 1'b1;
    check_half(0, 1, "R4 ref default seed");
    check_half(1, 2, "R4 fb default seed");
    check_half(2, 1, "R4 post default code");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule